// File: doc/BRIEF.md
# Power Button Conditioner

This block turns a noisy, active-low mechanical power button into clean system events. The raw button level is synchronized into the clock domain and then debounced against a 1 ms tick. Only a level that stays put for a full debounce window counts. A debounced press sets a press status bit. That bit, gated by a press enable, raises an event request on either the SMI or the SCI path, as chosen by a global routing select.

Once the press is accepted, a hold timer runs for as long as the debounced button stays down. If the override feature is enabled and the hold reaches its limit, the press status is replaced by a separate override status. A single-cycle soft-off request then goes to the power sequencer. Software clears both status bits with write-one-to-clear strobes. Debounce and hold lengths are parameters, counted in ticks, with defaults of 16 ms and 4 s.

Top module: `pwrbtn_ctrl`

## Requirements
- R1: The raw button is active low (0 = pressed) and passes through a two-flop synchronizer. A press is accepted only on the DEB_TICKS-th tick during which the synchronized level has stayed pressed. A shorter press leaves press_sts at 0.
- R2: If the synchronized level returns to the accepted level at any point during the debounce window, the tick count restarts from zero. The same rule debounces the release.
- R3: press_sts rises one clock after the press is accepted. An event request (smi_req or sci_req) is high exactly while press_sts and press_en are both 1.
- R4: The event goes to sci_req when route_sci is 1 and to smi_req when route_sci is 0. The two are never high together.
- R5: With ovr_en set, holding the debounced press for HOLD_TICKS ticks after acceptance clears press_sts and sets ovr_sts. A debounced release before that leaves press_sts at 1 and ovr_sts at 0.
- R6: softoff_req is a one-cycle pulse, one clock ahead of the status swap. It fires at most once per continuous hold and re-arms only after a debounced release.
- R7: press_clr and ovr_clr clear their status bit. A set in the same cycle as a clear wins.
- R8: With ovr_en at 0 the hold count saturates and no override occurs. Setting ovr_en while the button is still held past the limit triggers the override on the next clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| btn_raw_n | input | 1 | Raw power button, 0 = pressed |
| tick_1ms | input | 1 | One-cycle timing tick, nominally every 1 ms |
| press_en | input | 1 | Allows press_sts to raise an event request |
| ovr_en | input | 1 | Enables the long-hold override |
| route_sci | input | 1 | 1 routes events to SCI, 0 to SMI |
| press_clr | input | 1 | Write-one-to-clear strobe for press_sts |
| ovr_clr | input | 1 | Write-one-to-clear strobe for ovr_sts |
| press_sts | output | 1 | Debounced press status |
| ovr_sts | output | 1 | Override status |
| smi_req | output | 1 | Event request on the SMI path |
| sci_req | output | 1 | Event request on the SCI path |
| softoff_req | output | 1 | One-cycle soft-off request |

## Verification
The hardest situations to reach are the collisions: a status set landing in the same clock as its clear strobe. The override status is set two clocks after the last hold tick, so the stimulus has to count every register from that tick onward. The bench drives ticks as single-cycle pulses from known clock positions. It then issues the clear strobe in exactly the cycle in which the set lands. Debounce length and hold length are swept across their boundaries, with shortened parameters, and each run starts from a fully debounced release.

// File: rtl/pwrbtn_pkg.sv
// Shared definitions for the power button conditioner.
// Assumes: all users compile this package first.
package pwrbtn_pkg;
    // Default debounce length in ticks (16 ms at a 1 ms tick).
    localparam int unsigned DEF_DEB_TICKS  = 16;
    // Default override hold length in ticks (4 s at a 1 ms tick).
    localparam int unsigned DEF_HOLD_TICKS = 4000;

    // Status word kept by the status register module.
    typedef struct packed {
        logic ovr;
        logic press;
    } btn_sts_t;
endpackage

// File: rtl/pwrbtn_sync.sv
// Synchronizer chain for an asynchronous level input.
// Assumes: the input idles at 1 (button released), so reset loads ones.
module pwrbtn_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    // Shift the raw level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], din};
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/pwrbtn_debounce.sv
// Tick-based debounce: a new level is accepted only after it has been
// seen continuously for DEB_TICKS ticks. A return to the accepted level
// restarts the count.
// Assumes: din_n is already synchronous; tick is a one-cycle enable.
module pwrbtn_debounce #(
    parameter int unsigned DEB_TICKS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic din_n,
    output logic held,
    output logic press_evt
);
    localparam int unsigned CW = $clog2(DEB_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(DEB_TICKS - 1);

    logic          stable_n_q;
    logic [CW-1:0] cnt_q;

    // Count ticks while the input differs from the accepted level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stable_n_q <= 1'b1;
            cnt_q      <= '0;
            press_evt  <= 1'b0;
        end else begin
            press_evt <= 1'b0;
            if (din_n == stable_n_q) begin
                cnt_q <= '0;
            end else if (tick) begin
                if (cnt_q == LAST) begin
                    stable_n_q <= din_n;
                    cnt_q      <= '0;
                    press_evt  <= !din_n;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign held = !stable_n_q;

    AST_LEVEL_MOVES_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(stable_n_q)); // R1
    AST_EVT_MEANS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        press_evt |-> held); // R1
    AST_CNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST); // R2
endmodule

// File: rtl/pwrbtn_hold.sv
// Hold timer: counts ticks while the debounced button is down and
// issues a single override pulse once the hold limit is reached with
// the override enabled. Re-arms when the debounced button is released.
// Assumes: held comes from the debounce stage.
module pwrbtn_hold #(
    parameter int unsigned HOLD_TICKS = 4000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic held,
    input  logic ovr_en,
    output logic ovr_fire
);
    localparam int unsigned HW = $clog2(HOLD_TICKS + 1);
    localparam logic [HW-1:0] LIMIT = HW'(HOLD_TICKS);

    logic [HW-1:0] cnt_q;
    logic          fired_q;
    logic          reached;

    assign reached = (cnt_q == LIMIT);

    // Saturating hold count, once-per-hold override pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || !held) begin
            cnt_q    <= '0;
            fired_q  <= 1'b0;
            ovr_fire <= 1'b0;
        end else begin
            if (tick && !reached) cnt_q <= cnt_q + 1'b1;
            ovr_fire <= ovr_en && reached && !fired_q;
            fired_q  <= fired_q || (ovr_en && reached);
        end
    end

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_fire |=> !ovr_fire); // R6
    AST_FIRE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_fire |-> $past(ovr_en)); // R8
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LIMIT); // R5
endmodule

// File: rtl/pwrbtn_status.sv
// Status bits with write-one-to-clear strobes; a set beats a clear.
// The override set also clears the press bit.
// Assumes: press_set and ovr_set never coincide.
module pwrbtn_status
    import pwrbtn_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     press_set,
    input  logic     ovr_set,
    input  logic     press_clr,
    input  logic     ovr_clr,
    output btn_sts_t sts
);
    // Update press status: set, else cleared by override or strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)                    sts.press <= 1'b0;
        else if (press_set)            sts.press <= 1'b1;
        else if (ovr_set || press_clr) sts.press <= 1'b0;
    end

    // Update override status: set beats strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)       sts.ovr <= 1'b0;
        else if (ovr_set) sts.ovr <= 1'b1;
        else if (ovr_clr) sts.ovr <= 1'b0;
    end

    AST_OVR_SWAPS: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_set |=> sts.ovr && !sts.press); // R5
    AST_PRESS_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        press_set |=> sts.press); // R7
endmodule

// File: rtl/pwrbtn_ctrl.sv
// Power button conditioner top: synchronize, debounce, time the hold,
// keep status and route the event request to SMI or SCI.
// Assumes: tick_1ms is a one-cycle enable; clear strobes are one cycle.
module pwrbtn_ctrl
    import pwrbtn_pkg::*;
#(
    parameter int unsigned DEB_TICKS  = DEF_DEB_TICKS,
    parameter int unsigned HOLD_TICKS = DEF_HOLD_TICKS
) (
    input  logic clk,
    input  logic rst_n,
    input  logic btn_raw_n,
    input  logic tick_1ms,
    input  logic press_en,
    input  logic ovr_en,
    input  logic route_sci,
    input  logic press_clr,
    input  logic ovr_clr,
    output logic press_sts,
    output logic ovr_sts,
    output logic smi_req,
    output logic sci_req,
    output logic softoff_req
);
    logic     btn_s_n;
    logic     held;
    logic     press_evt;
    logic     ovr_fire;
    logic     evt;
    btn_sts_t sts;

    pwrbtn_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(btn_raw_n), .dout(btn_s_n)
    );

    pwrbtn_debounce #(.DEB_TICKS(DEB_TICKS)) u_deb (
        .clk(clk), .rst_n(rst_n), .tick(tick_1ms), .din_n(btn_s_n),
        .held(held), .press_evt(press_evt)
    );

    pwrbtn_hold #(.HOLD_TICKS(HOLD_TICKS)) u_hold (
        .clk(clk), .rst_n(rst_n), .tick(tick_1ms), .held(held),
        .ovr_en(ovr_en), .ovr_fire(ovr_fire)
    );

    pwrbtn_status u_sts (
        .clk(clk), .rst_n(rst_n), .press_set(press_evt), .ovr_set(ovr_fire),
        .press_clr(press_clr), .ovr_clr(ovr_clr), .sts(sts)
    );

    // Route the gated press event to one interrupt path.
    always_comb begin
        evt     = sts.press && press_en;
        smi_req = evt && !route_sci;
        sci_req = evt && route_sci;
    end

    assign press_sts   = sts.press;
    assign ovr_sts     = sts.ovr;
    assign softoff_req = ovr_fire;

    AST_ONE_PATH: assert property (@(posedge clk) disable iff (!rst_n)
        !(smi_req && sci_req)); // R4
    AST_REQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (smi_req || sci_req) |-> (press_sts && press_en)); // R3
    AST_SOFTOFF_THEN_STS: assert property (@(posedge clk) disable iff (!rst_n)
        softoff_req |=> ovr_sts && !press_sts); // R6
endmodule

// File: tb/pwrbtn_ctrl_bench.sv
module pwrbtn_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DEB  = 4;
    localparam int HOLD = 12;
    localparam int WATCHDOG = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic btn_raw_n = 1'b1;
    logic tick_1ms = 1'b0;
    logic press_en = 1'b0;
    logic ovr_en = 1'b0;
    logic route_sci = 1'b0;
    logic press_clr = 1'b0;
    logic ovr_clr = 1'b0;
    logic press_sts, ovr_sts, smi_req, sci_req, softoff_req;

    int n_tests = 0;
    int n_fail  = 0;
    int pulses  = 0;
    int cycles  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwrbtn_ctrl #(.DEB_TICKS(DEB), .HOLD_TICKS(HOLD)) u_pwrbtn_ctrl (
        .clk(clk), .rst_n(rst_n), .btn_raw_n(btn_raw_n), .tick_1ms(tick_1ms),
        .press_en(press_en), .ovr_en(ovr_en), .route_sci(route_sci),
        .press_clr(press_clr), .ovr_clr(ovr_clr), .press_sts(press_sts),
        .ovr_sts(ovr_sts), .smi_req(smi_req), .sci_req(sci_req),
        .softoff_req(softoff_req)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (softoff_req) pulses <= pulses + 1;
    end

    task automatic check(string tag, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            tick_1ms = 1'b1;
            @(negedge clk);
            tick_1ms = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic set_btn(logic v);
        btn_raw_n = v;
        idle(3);
    endtask

    task automatic full_release();
        set_btn(1'b1);
        ticks(DEB);
        idle(2);
    endtask

    task automatic clear_all();
        press_clr = 1'b1; ovr_clr = 1'b1;
        @(negedge clk);
        press_clr = 1'b0; ovr_clr = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        check("R3 reset press_sts", press_sts, 0);
        check("R5 reset ovr_sts", ovr_sts, 0);
        check("R6 reset softoff", softoff_req, 0);

        // R1: presses shorter than the debounce window are ignored
        for (int k = 0; k < DEB; k++) begin
            set_btn(1'b0);
            ticks(k);
            set_btn(1'b1);
            ticks(DEB);
            check($sformatf("R1 short press %0d ticks", k), press_sts, 0);
        end

        // R2: a bounce back restarts the debounce count
        set_btn(1'b0);
        ticks(DEB - 1);
        set_btn(1'b1);
        set_btn(1'b0);
        ticks(DEB - 1);
        check("R2 restart after bounce", press_sts, 0);
        ticks(1);
        check("R1 accepted at DEB ticks", press_sts, 1);

        // R3/R4: routing and enable sweep
        for (int c = 0; c < 4; c++) begin
            press_en  = c[0];
            route_sci = c[1];
            @(negedge clk);
            check($sformatf("R3 smi en=%0d sci=%0d", c[0], c[1]), smi_req, int'(c[0] && !c[1]));
            check($sformatf("R4 sci en=%0d sci=%0d", c[0], c[1]), sci_req, int'(c[0] && c[1]));
        end
        press_en = 1'b0;

        // R2: release also debounced; short release keeps button held
        set_btn(1'b1);
        ticks(DEB - 1);
        set_btn(1'b0);
        full_release();
        clear_all();
        check("R7 press clear", press_sts, 0);

        // R5/R6: hold length sweep around the limit
        ovr_en = 1'b1;
        for (int h = HOLD - 2; h <= HOLD + 2; h++) begin
            int base;
            base = pulses;
            set_btn(1'b0);
            ticks(DEB + h);
            idle(3);
            check($sformatf("R6 pulses hold %0d", h), pulses - base, int'(h >= HOLD));
            check($sformatf("R5 press_sts hold %0d", h), press_sts, int'(h < HOLD));
            check($sformatf("R5 ovr_sts hold %0d", h), ovr_sts, int'(h >= HOLD));
            full_release();
            clear_all();
        end

        // R6: re-arm after debounced release
        begin
            int base;
            base = pulses;
            set_btn(1'b0);
            ticks(DEB + HOLD + 3);
            set_btn(1'b1);
            ticks(DEB - 1);
            set_btn(1'b0);
            ticks(3);
            idle(2);
            check("R6 no refire without full release", pulses - base, 1);
            full_release();
            set_btn(1'b0);
            ticks(DEB + HOLD);
            idle(3);
            check("R6 re-armed after release", pulses - base, 2);
            full_release();
            clear_all();
        end

        // R8: override disabled, then enabled while held
        begin
            int base;
            base = pulses;
            ovr_en = 1'b0;
            set_btn(1'b0);
            ticks(DEB + HOLD + 3);
            idle(3);
            check("R8 no override when disabled", pulses - base, 0);
            check("R8 press kept when disabled", press_sts, 1);
            ovr_en = 1'b1;
            idle(3);
            check("R8 late enable fires", pulses - base, 1);
            check("R8 late enable ovr_sts", ovr_sts, 1);
            full_release();
            clear_all();
        end

        // R7: press set and clear in the same cycle
        set_btn(1'b0);
        ticks(DEB - 1);
        tick_1ms = 1'b1;
        @(negedge clk);
        tick_1ms = 1'b0; press_clr = 1'b1;
        @(negedge clk);
        press_clr = 1'b0;
        @(negedge clk);
        check("R7 press set beats clear", press_sts, 1);

        // R7: override set and clear in the same cycle
        ticks(HOLD - 1);
        tick_1ms = 1'b1;
        @(negedge clk);
        tick_1ms = 1'b0;
        @(negedge clk);
        ovr_clr = 1'b1;
        @(negedge clk);
        ovr_clr = 1'b0;
        @(negedge clk);
        check("R7 ovr set beats clear", ovr_sts, 1);
        check("R5 press cleared by override", press_sts, 0);
        ovr_clr = 1'b1;
        @(negedge clk);
        ovr_clr = 1'b0;
        @(negedge clk);
        check("R7 ovr clear alone", ovr_sts, 0);
        full_release();

        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        while (cycles < WATCHDOG) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d cycles", cycles, WATCHDOG);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule